// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block turns a fast peripheral clock into the timing skeleton of an I2C serial clock. It runs in two stages. A prescaler divides the input clock by (1 + CDF) and emits a one-cycle internal tick. A phase controller then counts ticks to build the SCL low and high phases. A full SCL period lasts 20 + 8*SCGD + R ticks. The fixed overhead and the SCGD part are split evenly into the low phase and the first share of the high phase. R is a programmable compensation for rise time, fall time and internal delay, and it lengthens only the high phase.

CDF and SCGD arrive packed in one configuration word. CDF sits in the low CDF_W bits, and SCGD is placed directly above it. A bit engine uses the tick strobe to step once per tick. It uses the period strobe to align data changes with each falling SCL edge, and the first-bit strobe to know when the very first SCL edge of a run occurs. An optional setup delay of 17 ticks keeps SCL high after the run starts, which gives the first SDA change time to settle.

Configuration is sampled when a run starts and again at every period boundary, so a change never distorts the period that is already in progress. Any word whose CDF would let the tick reach 20 MHz or more is flagged as unusable and is never adopted.

Top module: `scl_clk_gen`

## Requirements
- R1: While running, `tick_stb` is high for exactly one clock in every 1 + CDF clocks, where CDF is `cfg_word[CDF_W-1:0]` of the adopted configuration.
- R2: `cfg_bad` is high whenever the CDF field of `cfg_word` is below CLK_HZ / 20 MHz. With such a word the block does not start, and at a period boundary the word is ignored and the previous configuration stays in use.
- R3: Consecutive `period_stb` pulses are (1 + CDF) * (20 + 8*SCGD + R) clocks apart. Each pulse marks the first clock of an SCL low phase.
- R4: `scl_out` is 0 for (1 + CDF) * (10 + 4*SCGD) clocks of each period and 1 for the rest of the period.
- R5: SCGD is taken from `cfg_word[CDF_W+5:CDF_W]` (6 bits, values 0 to 63), and CDF from the bits below it.
- R6: When `setup_code` equals 0x0F at start, `scl_out` stays high for 17 ticks before the first low phase. With any other code, the first low phase begins in the clock after start. `first_bit_stb` pulses together with the first `period_stb` of a run and at no other time.
- R7: A configuration word changed in the middle of a period takes effect only from the next period boundary.
- R8: One clock after `enable` is low, `scl_out` is 1 and `tick_stb` and `period_stb` are 0. Raising `enable` again starts a fresh run.
- R9: `low_ticks` equals 10 + 4*SCGD and `high_ticks` equals 10 + 4*SCGD + R for the configuration in use. Both are 10 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run request; low returns the block to idle |
| cfg_word | input | CDF_W+6 | Packed divider word: SCGD above CDF |
| rnd_cnt | input | RND_W | Compensation ticks R added to the high phase |
| setup_code | input | 4 | 0x0F enables the 17-tick first-bit setup delay |
| tick_stb | output | 1 | One-clock internal tick |
| scl_out | output | 1 | SCL timing level (1 = released high) |
| period_stb | output | 1 | First clock of each SCL low phase |
| first_bit_stb | output | 1 | First clock of the first low phase of a run |
| cfg_bad | output | 1 | CDF field of `cfg_word` is too small for the input clock |
| low_ticks | output | LEN_W | Low phase length in ticks for the adopted configuration |
| high_ticks | output | LEN_W | High phase length in ticks for the adopted configuration |

## Verification
A wrong prescaler count makes `tick_stb` show up in the wrong clock. The bench sees this within 1 + CDF clocks of the fault. A corrupted tick or phase counter moves the next `scl_out` edge or `period_stb`, so the mismatch appears before one SCL period has passed. A shadow register loaded at the wrong time is visible in `low_ticks` and `high_ticks` in the very next clock, and in the period length one boundary later. A broken start or enable path shows up as an early or missing `first_bit_stb` within 1 + 17*(1 + CDF) clocks.

// File: rtl/scl_gen_pkg.sv
// Shared constants and types for the SCL timing generator.
// Assumes: lengths are counted in internal ticks, not input clocks.
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_LOW   = 2'd2,
        PH_HIGH  = 2'd3
    } scl_phase_e;

    localparam int TICK_LIMIT_HZ = 20_000_000;
    localparam int BASE_TICKS    = 20;
    localparam int HALF_BASE     = BASE_TICKS / 2;
    localparam int STEP_SHIFT    = 2;      // 8 ticks per SCGD step, half in low phase
    localparam int SETUP_TICKS   = 17;
    localparam logic [3:0] SETUP_KEY = 4'hF;

endpackage

// File: rtl/scl_cfg_shadow.sv
// Configuration shadow: unpacks the divider word, judges its CDF field
// against the minimum legal value and holds the adopted copy.
// Assumes: load is a single-cycle request from the phase controller.
module scl_cfg_shadow #(
    parameter int CDF_W   = 3,
    parameter int SCGD_W  = 6,
    parameter int RND_W   = 6,
    parameter int MIN_CDF = 5,
    localparam int CFG_W  = CDF_W + SCGD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [RND_W-1:0]  rnd_cnt,
    output logic              cfg_bad,
    output logic [CDF_W-1:0]  cdf_sh,
    output logic [SCGD_W-1:0] scgd_sh,
    output logic [RND_W-1:0]  rnd_sh
);

    logic [CDF_W-1:0]  in_cdf;
    logic [SCGD_W-1:0] in_scgd;

    assign in_cdf  = cfg_word[CDF_W-1:0];
    assign in_scgd = cfg_word[CFG_W-1:CDF_W];

    // Flag a word whose tick would run at or above the tick limit
    assign cfg_bad = (int'(in_cdf) < MIN_CDF);

    // Adopt a legal word only on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cdf_sh  <= '0;
            scgd_sh <= '0;
            rnd_sh  <= '0;
        end else if (load && !cfg_bad) begin
            cdf_sh  <= in_cdf;
            scgd_sh <= in_scgd;
            rnd_sh  <= rnd_cnt;
        end
    end

endmodule

// File: rtl/scl_prescaler.sv
// First divider stage: counts input clocks and emits one tick every
// (1 + cdf) clocks while run is high.
// Assumes: cdf only changes in the cycle after a tick (period boundary).
module scl_prescaler #(
    parameter int CDF_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CDF_W-1:0] cdf,
    output logic             tick
);

    logic [CDF_W-1:0] pre_cnt;

    assign tick = run && (pre_cnt == cdf);

    // Count clocks within one tick interval, restarting when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (!run || tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/scl_phase_ctrl.sv
// Second divider stage: sequences setup, low and high phases in ticks,
// raises the load request for the configuration shadow at start and at
// every period boundary, and registers the period and first-bit strobes.
// Assumes: scgd and rnd come from the shadow and are stable within a period.
module scl_phase_ctrl
    import scl_gen_pkg::*;
#(
    parameter int SCGD_W = 6,
    parameter int RND_W  = 6,
    parameter int LEN_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cfg_bad,
    input  logic [3:0]        setup_code,
    input  logic              tick,
    input  logic [SCGD_W-1:0] scgd,
    input  logic [RND_W-1:0]  rnd,
    output logic              run,
    output logic              load,
    output scl_phase_e        phase,
    output logic [LEN_W-1:0]  low_len,
    output logic [LEN_W-1:0]  high_len,
    output logic              period_stb,
    output logic              first_stb
);

    logic [LEN_W-1:0] tick_cnt;
    logic [LEN_W-1:0] cur_len;
    logic             start;
    logic             setup_on;
    logic             phase_end;

    assign low_len  = LEN_W'(HALF_BASE) + (LEN_W'(scgd) << STEP_SHIFT);
    assign high_len = low_len + LEN_W'(rnd);
    assign setup_on = (setup_code == SETUP_KEY);
    assign start    = enable && !run && !cfg_bad;

    // Select the length of the phase now being counted
    always_comb begin
        case (phase)
            PH_SETUP: cur_len = LEN_W'(SETUP_TICKS);
            PH_LOW:   cur_len = low_len;
            default:  cur_len = high_len;
        endcase
    end

    assign phase_end = run && enable && tick && (tick_cnt == cur_len - 1'b1);
    assign load      = start || (phase_end && (phase == PH_HIGH));

    // Advance the phase sequence one tick at a time
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            run        <= 1'b0;
            phase      <= PH_IDLE;
            tick_cnt   <= '0;
            period_stb <= 1'b0;
            first_stb  <= 1'b0;
        end else if (start) begin
            run        <= 1'b1;
            tick_cnt   <= '0;
            phase      <= setup_on ? PH_SETUP : PH_LOW;
            period_stb <= !setup_on;
            first_stb  <= !setup_on;
        end else begin
            period_stb <= 1'b0;
            first_stb  <= 1'b0;
            if (run && tick) begin
                if (phase_end) begin
                    tick_cnt <= '0;
                    case (phase)
                        PH_SETUP: begin
                            phase      <= PH_LOW;
                            period_stb <= 1'b1;
                            first_stb  <= 1'b1;
                        end
                        PH_LOW:   phase <= PH_HIGH;
                        default: begin
                            phase      <= PH_LOW;
                            period_stb <= 1'b1;
                        end
                    endcase
                end else begin
                    tick_cnt <= tick_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/scl_clk_gen.sv
// Top of the SCL timing generator: prescaler, configuration shadow and
// phase controller. Outputs timing only; pad drive and target clock
// stretching are handled elsewhere.
// Assumes: CDF_W is 2 or 3; CLK_HZ is the frequency of clk.
module scl_clk_gen
    import scl_gen_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int CDF_W   = 3,
    parameter int SCGD_W  = 6,
    parameter int RND_W   = 6,
    localparam int CFG_W    = CDF_W + SCGD_W,
    localparam int MIN_CDF  = CLK_HZ / TICK_LIMIT_HZ,
    localparam int MAX_HIGH = HALF_BASE + (((1 << SCGD_W) - 1) << STEP_SHIFT)
                              + ((1 << RND_W) - 1),
    localparam int LEN_W    = $clog2(MAX_HIGH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [RND_W-1:0]  rnd_cnt,
    input  logic [3:0]        setup_code,
    output logic              tick_stb,
    output logic              scl_out,
    output logic              period_stb,
    output logic              first_bit_stb,
    output logic              cfg_bad,
    output logic [LEN_W-1:0]  low_ticks,
    output logic [LEN_W-1:0]  high_ticks
);

    logic              run_q;
    logic              load;
    logic [CDF_W-1:0]  cdf_sh;
    logic [SCGD_W-1:0] scgd_sh;
    logic [RND_W-1:0]  rnd_sh;
    scl_phase_e        phase;

    scl_cfg_shadow #(
        .CDF_W   (CDF_W),
        .SCGD_W  (SCGD_W),
        .RND_W   (RND_W),
        .MIN_CDF (MIN_CDF)
    ) i_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cfg_word (cfg_word),
        .rnd_cnt  (rnd_cnt),
        .cfg_bad  (cfg_bad),
        .cdf_sh   (cdf_sh),
        .scgd_sh  (scgd_sh),
        .rnd_sh   (rnd_sh)
    );

    scl_prescaler #(
        .CDF_W (CDF_W)
    ) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .cdf   (cdf_sh),
        .tick  (tick_stb)
    );

    scl_phase_ctrl #(
        .SCGD_W (SCGD_W),
        .RND_W  (RND_W),
        .LEN_W  (LEN_W)
    ) i_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cfg_bad    (cfg_bad),
        .setup_code (setup_code),
        .tick       (tick_stb),
        .scgd       (scgd_sh),
        .rnd        (rnd_sh),
        .run        (run_q),
        .load       (load),
        .phase      (phase),
        .low_len    (low_ticks),
        .high_len   (high_ticks),
        .period_stb (period_stb),
        .first_stb  (first_bit_stb)
    );

    assign scl_out = (phase != PH_LOW);

endmodule

// File: rtl/scl_clk_gen_chk.sv
// Property checker for the SCL timing generator, bound to every instance.
// Assumes: synchronous active-low reset on clk.
module scl_clk_gen_chk #(
    parameter int CDF_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             tick_stb,
    input logic             scl_out,
    input logic             period_stb,
    input logic             first_bit_stb,
    input logic             cfg_bad,
    input logic             run_q,
    input logic [CDF_W-1:0] cdf_sh
);

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_stb && cdf_sh != '0) |=> !tick_stb);                     // R1

    AST_BAD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cfg_bad && !run_q) |=> !run_q);                      // R2

    AST_FALL_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_out) |-> period_stb);                                 // R3

    AST_STB_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb |-> !scl_out);                                       // R3

    AST_LOW_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb |=> (!period_stb && !scl_out));                      // R4

    AST_FIRST_WITH_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        first_bit_stb |-> period_stb);                                  // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_out && !tick_stb && !period_stb));             // R8

endmodule

bind scl_clk_gen scl_clk_gen_chk #(.CDF_W(CDF_W)) i_scl_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .tick_stb      (tick_stb),
    .scl_out       (scl_out),
    .period_stb    (period_stb),
    .first_bit_stb (first_bit_stb),
    .cfg_bad       (cfg_bad),
    .run_q         (run_q),
    .cdf_sh        (cdf_sh)
);

// File: tb/test_scl_clk_gen.sv
// Bench for the SCL timing generator: a behavioural per-clock model plus
// scenario checks that measure periods in input clocks.
module test_scl_clk_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       enable;
    logic [8:0] cfg_word;
    logic [5:0] rnd_cnt;
    logic [3:0] setup_code;
    logic       tick_stb, scl_out, period_stb, first_bit_stb, cfg_bad;
    logic [8:0] low_ticks, high_ticks;

    int  n_chk = 0;
    int  n_err = 0;
    bit  cmp_on = 1'b0;
    bit  done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    scl_clk_gen #(
        .CLK_HZ (50_000_000),
        .CDF_W  (3),
        .SCGD_W (6),
        .RND_W  (6)
    ) i_scl_clk_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .cfg_word      (cfg_word),
        .rnd_cnt       (rnd_cnt),
        .setup_code    (setup_code),
        .tick_stb      (tick_stb),
        .scl_out       (scl_out),
        .period_stb    (period_stb),
        .first_bit_stb (first_bit_stb),
        .cfg_bad       (cfg_bad),
        .low_ticks     (low_ticks),
        .high_ticks    (high_ticks)
    );

    localparam int MINC = 2;   // 50 MHz / 20 MHz

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] mk(input int scgd, input int cdf);
        return 9'((scgd << 3) | cdf);   // R5 packing
    endfunction

    // ---------------- behavioural reference model ----------------
    int m_run, m_ph, m_pc, m_tc, m_cdf, m_scgd, m_rnd, m_pstb, m_fstb;

    always @(posedge clk) begin
        int in_cdf, len;
        bit tk;
        in_cdf = int'(cfg_word[2:0]);
        if (!rst_n) begin
            m_run = 0; m_ph = 0; m_pc = 0; m_tc = 0;
            m_cdf = 0; m_scgd = 0; m_rnd = 0; m_pstb = 0; m_fstb = 0;
        end else if (!enable) begin
            m_run = 0; m_ph = 0; m_pc = 0; m_tc = 0; m_pstb = 0; m_fstb = 0;
        end else if (m_run == 0) begin
            if (in_cdf >= MINC) begin
                m_cdf = in_cdf; m_scgd = int'(cfg_word[8:3]); m_rnd = int'(rnd_cnt);
                m_run = 1; m_pc = 0; m_tc = 0;
                if (setup_code == 4'hF) begin
                    m_ph = 1; m_pstb = 0; m_fstb = 0;
                end else begin
                    m_ph = 2; m_pstb = 1; m_fstb = 1;
                end
            end
        end else begin
            tk = (m_pc == m_cdf);
            m_pstb = 0; m_fstb = 0;
            m_pc = tk ? 0 : m_pc + 1;
            if (tk) begin
                len = (m_ph == 1) ? 17 : (m_ph == 2) ? 10 + 4*m_scgd
                                                     : 10 + 4*m_scgd + m_rnd;
                if (m_tc == len - 1) begin
                    m_tc = 0;
                    if (m_ph == 1) begin
                        m_ph = 2; m_pstb = 1; m_fstb = 1;
                    end else if (m_ph == 2) begin
                        m_ph = 3;
                    end else begin
                        m_ph = 2; m_pstb = 1;
                        if (in_cdf >= MINC) begin
                            m_cdf = in_cdf; m_scgd = int'(cfg_word[8:3]); m_rnd = int'(rnd_cnt);
                        end
                    end
                end else begin
                    m_tc++;
                end
            end
        end
    end

    // Compare every output with the model on every clock
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R1 tick_stb", tick_stb, (m_run != 0 && m_pc == m_cdf) ? 1 : 0);
            chk("R4 scl_out", scl_out, (m_ph != 2) ? 1 : 0);
            chk("R3 period_stb", period_stb, m_pstb);
            chk("R6 first_bit_stb", first_bit_stb, m_fstb);
            chk("R2 cfg_bad", cfg_bad, (int'(cfg_word[2:0]) < MINC) ? 1 : 0);
            chk("R9 low_ticks", low_ticks, 10 + 4*m_scgd);
            chk("R9 high_ticks", high_ticks, 10 + 4*m_scgd + m_rnd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input bit en, input logic [8:0] w, input int r, input logic [3:0] s);
        @(negedge clk);
        #1;
        enable = en; cfg_word = w; rnd_cnt = 6'(r); setup_code = s;
    endtask

    task automatic wait_first(output int n, output int lows);
        n = 0; lows = 0;
        do begin
            @(negedge clk);
            n++;
            if (!scl_out && !first_bit_stb) lows++;
        end while (!first_bit_stb);
    endtask

    task automatic wait_stb();
        do @(negedge clk); while (!period_stb);
    endtask

    // Called at a negedge showing period_stb; ends at the next one
    task automatic measure(output int gap, output int lows, output int firsts);
        gap = 0; lows = 1; firsts = 0;
        forever begin
            @(negedge clk);
            gap++;
            if (period_stb) break;
            if (!scl_out) lows++;
            if (first_bit_stb) firsts++;
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        int n, lows, gap, fr, ticks, stbs;
        rst_n = 1'b0; enable = 1'b0; cfg_word = '0; rnd_cnt = '0; setup_code = '0;
        @(posedge clk);
        cmp_on = 1'b1;
        @(negedge clk);
        chk("reset scl_out", scl_out, 1);
        chk("reset tick_stb", tick_stb, 0);
        chk("reset period_stb", period_stb, 0);
        chk("R9 reset low_ticks", low_ticks, 10);
        chk("R2 reset cfg_bad with CDF 0", cfg_bad, 1);
        #1 rst_n = 1'b1;

        // Plain start, cdf 2, scgd 0, R 3
        drive(1, mk(0, 2), 3, 4'h0);
        wait_first(n, lows);
        chk("R6 first edge without setup", n, 1);
        measure(gap, lows, fr);
        chk("R3 period cdf2 scgd0 r3", gap, 3 * 23);
        chk("R4 low cdf2 scgd0", lows, 3 * 10);

        // Disable then restart with cdf 3, scgd 2
        drive(0, mk(0, 2), 3, 4'h0);
        @(negedge clk);
        chk("R8 scl high after disable", scl_out, 1);
        chk("R8 no tick after disable", tick_stb, 0);
        drive(1, mk(2, 3), 0, 4'h0);
        wait_first(n, lows);
        chk("R8 fresh restart first edge", n, 1);
        measure(gap, lows, fr);
        chk("R5 R3 period cdf3 scgd2", gap, 4 * 36);
        chk("R4 low cdf3 scgd2", lows, 4 * 18);
        chk("R9 low_ticks scgd2", low_ticks, 18);
        chk("R9 high_ticks scgd2", high_ticks, 18);

        // Setup delay enabled
        drive(0, mk(2, 3), 0, 4'h0);
        drive(1, mk(1, 2), 1, 4'hF);
        wait_first(n, lows);
        chk("R6 setup delay clocks", n, 1 + 17 * 3);
        chk("R6 scl high during setup", lows, 0);
        measure(gap, lows, fr);
        chk("R3 period with setup run", gap, 3 * 29);
        chk("R4 low scgd1", lows, 3 * 14);
        measure(gap, lows, fr);
        chk("R6 no repeat first_bit_stb", fr, 0);

        // Setup code other than 0x0F: no delay
        drive(0, mk(1, 2), 1, 4'h0);
        drive(1, mk(1, 2), 1, 4'hE);
        wait_first(n, lows);
        chk("R6 code 0x0E gives no delay", n, 1);

        // Illegal CDF: never starts
        drive(0, mk(1, 2), 1, 4'h0);
        drive(1, mk(0, 1), 0, 4'h0);
        ticks = 0; lows = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tick_stb) ticks++;
            if (!scl_out) lows++;
        end
        chk("R2 cfg_bad for CDF 1", cfg_bad, 1);
        chk("R2 no tick with bad word", ticks, 0);
        chk("R2 scl stays high with bad word", lows, 0);

        // Mid-period change waits for the boundary
        drive(0, mk(0, 1), 0, 4'h0);
        drive(1, mk(0, 2), 0, 4'h0);
        wait_stb();
        gap = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            gap++;
        end
        #1 cfg_word = mk(1, 2);
        do begin
            @(negedge clk);
            gap++;
        end while (!period_stb);
        chk("R7 current period keeps old length", gap, 60);
        measure(gap, lows, fr);
        chk("R7 next period uses new word", gap, 84);

        // Illegal word at boundary is ignored
        #1 cfg_word = mk(1, 1);
        measure(gap, lows, fr);
        chk("R2 bad word ignored, period 1", gap, 84);
        measure(gap, lows, fr);
        chk("R2 bad word ignored, period 2", gap, 84);

        // Drop enable in mid low phase
        for (int i = 0; i < 7; i++) @(negedge clk);
        #1 enable = 1'b0;
        ticks = 0; stbs = 0; lows = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (tick_stb) ticks++;
            if (period_stb) stbs++;
            if (!scl_out) lows++;
        end
        chk("R8 no ticks while disabled", ticks, 0);
        chk("R8 no period_stb while disabled", stbs, 0);
        chk("R8 scl high while disabled", lows, 0);
        drive(1, mk(0, 2), 0, 4'h0);
        wait_first(n, lows);
        chk("R8 restart after disable", n, 1);
        measure(gap, lows, fr);
        chk("R1 R3 restart period", gap, 60);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule